// File: doc/BRIEF.md
# DMA Completion Response Queue

This block keeps one completion record for every descriptor the DMA engine finishes. A record holds two things: the byte count that was moved, and a status made of eight error bits and an early-termination flag. The engine writes a record with a single-cycle push strobe. The queue keeps records in arrival order until the host collects them.

The host reads records through a window two words wide, addressed by byte offset. Offset 0x00 returns the byte count of the oldest record. Reading it has no side effect, so it may be read as often as needed. Offset 0x04 returns the status word of the oldest record, and reading it removes that record from the queue. The host therefore consumes one entry by reading the byte count first and the status second.

Read data is registered and appears on the cycle after the read strobe. The queue also exports three outputs for the control/status logic: a fill count, a full flag and an empty flag. It exports a sticky flag as well, which records any completion that arrived while the queue was full.

Top module: `dma_resp_queue`

## Requirements
- R1: After reset the queue is empty: `respEmpty`=1, `respFull`=0, `fillLevel`=0, `overflowFlag`=0 and `rdData`=0.
- R2: Each accepted push stores one record and raises `fillLevel` by one. Records are handed to the host in the order they were pushed.
- R3: A read with `rdAddr[2]`=0 (offset 0x00) returns the head record's byte count on `rdData` one cycle later. It does not change `fillLevel` or the head, so repeated reads return the same value.
- R4: A read with `rdAddr[2]`=1 (offset 0x04) returns the head record's status one cycle later and removes the head. The status word holds the error bits in bits 7:0, the early-termination flag in bit 8, and zero in bits 31:9.
- R5: A read of either offset while the queue is empty returns 0. It leaves `fillLevel` at 0 and does not underflow it.
- R6: A push while `fillLevel` equals DEPTH (default 16) is dropped, even if a pop happens in the same cycle. The dropped push sets `overflowFlag`, which then stays at 1 until reset.
- R7: `respFull` is 1 exactly when `fillLevel` equals DEPTH. `respEmpty` is 1 exactly when `fillLevel` is 0.
- R8: A push together with a status-word read, when 0 < `fillLevel` < DEPTH, leaves `fillLevel` unchanged. The read returns the old head's status, and the pushed record joins the tail.
- R9: `fillLevel` is a 16-bit count of the stored records and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Engine presents a completion record this cycle |
| pushBytes | input | 32 | Byte count of the completed descriptor |
| pushErr | input | 8 | Error bits of the completed descriptor |
| pushEarly | input | 1 | Early-termination flag of the completed descriptor |
| rdEn | input | 1 | Host read strobe for the window |
| rdAddr | input | 3 | Byte offset within the window; bit 2 selects the status word |
| rdData | output | 32 | Registered read data, valid the cycle after `rdEn` |
| fillLevel | output | 16 | Number of stored records |
| respFull | output | 1 | Queue holds DEPTH records |
| respEmpty | output | 1 | Queue holds no records |
| overflowFlag | output | 1 | Sticky: a push arrived while full |

## Verification
The hardest case to reach from the ports is a full queue that receives a push and a popping status read in the same cycle. The pop must still take effect while the push is dropped, leaving the queue one short of full with the overflow flag set. The stimulus fills the queue to its depth and confirms the full flag. It then offers one extra push alone, and after that issues a push together with a status read. Finally it drains every entry and checks that none of the dropped records ever appears.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic doPush;    // write incoming record at tail
    logic doPop;     // advance head
    logic rdStrobe;  // capture a window word into rdData
    logic selStatus; // 1: status word, 0: byte count
    logic headValid; // queue held a record when the read was issued
  } qStrobe_t;
endpackage

// File: rtl/dma_resp_ctrl.sv
module dma_resp_ctrl
  import dma_resp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             rdEn,
  input  logic             rdSelStatus,
  output qStrobe_t         stb,
  output logic [CNT_W-1:0] count,
  output logic             isFull,
  output logic             isEmpty,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  assign isFull  = (count == CNT_MAX);
  assign isEmpty = (count == '0);

  always_comb begin
    stb.doPush    = pushValid && !isFull;
    stb.doPop     = rdEn && rdSelStatus && !isEmpty;
    stb.rdStrobe  = rdEn;
    stb.selStatus = rdSelStatus;
    stb.headValid = !isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      case ({stb.doPush, stb.doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pushValid && isFull) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_resp_data.sv
module dma_resp_data
  import dma_resp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          stb,
  input  logic [DATA_W-1:0] pushBytes,
  input  logic [ERR_W-1:0]  pushErr,
  input  logic              pushEarly,
  output logic [DATA_W-1:0] rdData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int REC_W = DATA_W + ERR_W + 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [REC_W-1:0] headRec;
  logic [DATA_W-1:0] statusWord, bytesWord;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign headRec    = mem[rdPtr];
  assign bytesWord  = headRec[REC_W-1 -: DATA_W];
  assign statusWord = DATA_W'(headRec[ERR_W:0]);

  always_ff @(posedge clk) begin
    if (stb.doPush) mem[wrPtr] <= {pushBytes, pushEarly, pushErr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (stb.doPush) wrPtr <= nextPtr(wrPtr);
      if (stb.doPop)  rdPtr <= nextPtr(rdPtr);
      if (stb.rdStrobe) begin
        if (!stb.headValid)    rdData <= '0;
        else if (stb.selStatus) rdData <= statusWord;
        else                   rdData <= bytesWord;
      end
    end
  end
endmodule

// File: rtl/dma_resp_queue.sv
module dma_resp_queue
  import dma_resp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8,
  parameter int FILL_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushBytes,
  input  logic [ERR_W-1:0]  pushErr,
  input  logic              pushEarly,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [FILL_W-1:0] fillLevel,
  output logic              respFull,
  output logic              respEmpty,
  output logic              overflowFlag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t         stb;
  logic [CNT_W-1:0] count;

  dma_resp_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .rdEn(rdEn),
    .rdSelStatus(rdAddr[2]), .stb(stb), .count(count),
    .isFull(respFull), .isEmpty(respEmpty), .overflow(overflowFlag)
  );

  dma_resp_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .pushBytes(pushBytes),
    .pushErr(pushErr), .pushEarly(pushEarly), .rdData(rdData)
  );

  assign fillLevel = FILL_W'(count);
endmodule

// File: rtl/dma_resp_queue_chk.sv
module dma_resp_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int FILL_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [FILL_W-1:0] fillLevel,
  input logic              respFull,
  input logic              respEmpty,
  input logic              overflowFlag
);
  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FILL_W'(DEPTH));

  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respFull, respEmpty}));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && respFull && !(rdEn && rdAddr[2])
    |=> $stable(fillLevel) && overflowFlag);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && respEmpty && !pushValid |=> rdData == '0 && fillLevel == '0);

  assert_peek_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !rdAddr[2] && !pushValid |=> $stable(fillLevel));

  assert_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr[2] && !respEmpty && !pushValid
    |=> fillLevel == $past(fillLevel) - 1'b1);

  assert_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr[2] && pushValid && !respEmpty && !respFull
    |=> $stable(fillLevel));
endmodule

bind dma_resp_queue dma_resp_queue_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .FILL_W(FILL_W), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .rdEn(rdEn),
  .rdAddr(rdAddr), .rdData(rdData), .fillLevel(fillLevel),
  .respFull(respFull), .respEmpty(respEmpty), .overflowFlag(overflowFlag)
);

// File: tb/tb_dma_resp_queue.sv
module tb_dma_resp_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [31:0] b;
    logic [7:0]  e;
    logic        x;
  } rec_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic pushValid = 1'b0, pushEarly = 1'b0, rdEn = 1'b0;
  logic [31:0] pushBytes = '0;
  logic [7:0]  pushErr = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [15:0] fillLevel;
  logic respFull, respEmpty, overflowFlag;

  int total = 0, bad = 0;
  bit finished = 0;
  rec_t model[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_resp_queue #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushBytes(pushBytes),
    .pushErr(pushErr), .pushEarly(pushEarly), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .fillLevel(fillLevel), .respFull(respFull),
    .respEmpty(respEmpty), .overflowFlag(overflowFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] statusOf(input rec_t r);
    return {23'b0, r.x, r.e};
  endfunction

  function automatic rec_t mk(input int n);
    rec_t r;
    r.b = 32'h1000_0000 + 32'(n * 37);
    r.e = 8'(n * 5 + 1);
    r.x = n[0];
    return r;
  endfunction

  // Drive on negedge, result visible at the next negedge.
  task automatic cycle(input bit doPush, input rec_t r, input bit doRd, input bit stat);
    @(negedge clk);
    pushValid = doPush; pushBytes = r.b; pushErr = r.e; pushEarly = r.x;
    rdEn = doRd; rdAddr = stat ? 3'd4 : 3'd0;
    @(negedge clk);
    pushValid = 1'b0; rdEn = 1'b0;
  endtask

  task automatic pushRec(input rec_t r);
    cycle(1'b1, r, 1'b0, 1'b0);
    if (model.size() < DEPTH) model.push_back(r);
  endtask

  task automatic peekCheck(input string req);
    cycle(1'b0, '0, 1'b1, 1'b0);
    chk(req, rdData, model.size() > 0 ? model[0].b : 32'h0);
  endtask

  task automatic popCheck(input string req);
    logic [31:0] exp;
    exp = model.size() > 0 ? statusOf(model[0]) : 32'h0;
    cycle(1'b0, '0, 1'b1, 1'b1);
    if (model.size() > 0) void'(model.pop_front());
    chk(req, rdData, exp);
    chk(req, 32'(fillLevel), 32'(model.size()));
  endtask

  task automatic t_reset;
    chk("R1 fill", 32'(fillLevel), 0);
    chk("R1 empty", 32'(respEmpty), 1);
    chk("R1 full", 32'(respFull), 0);
    chk("R1 ovf", 32'(overflowFlag), 0);
    chk("R1 rdData", rdData, 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++) pushRec(mk(i));
    chk("R2 fill after 3 pushes", 32'(fillLevel), 3);
    chk("R9 fill", 32'(fillLevel), 3);
    peekCheck("R3 first peek");
    peekCheck("R3 repeated peek");
    chk("R3 fill unchanged", 32'(fillLevel), 3);
    for (int i = 0; i < 3; i++) begin
      peekCheck("R2 order bytes");
      popCheck("R4 status pop");
    end
    chk("R7 empty after drain", 32'(respEmpty), 1);
  endtask

  task automatic t_empty;
    popCheck("R5 empty status read");
    peekCheck("R5 empty bytes read");
    chk("R5 fill stays 0", 32'(fillLevel), 0);
  endtask

  task automatic t_pair;
    rec_t a, b;
    a = mk(20); b = mk(21);
    pushRec(a);
    cycle(1'b1, b, 1'b1, 1'b1);
    chk("R8 pair status", rdData, statusOf(a));
    chk("R8 pair fill", 32'(fillLevel), 1);
    void'(model.pop_front()); model.push_back(b);
    peekCheck("R8 pushed record at head");
    popCheck("R8 drain");
  endtask

  task automatic t_full;
    logic [31:0] exp;
    for (int i = 0; i < DEPTH; i++) pushRec(mk(40 + i));
    chk("R7 full flag", 32'(respFull), 1);
    chk("R9 fill at depth", 32'(fillLevel), DEPTH);
    chk("R6 no ovf yet", 32'(overflowFlag), 0);
    pushRec(mk(99));
    chk("R6 fill after dropped push", 32'(fillLevel), DEPTH);
    chk("R6 ovf set", 32'(overflowFlag), 1);
    exp = statusOf(model[0]);
    cycle(1'b1, mk(98), 1'b1, 1'b1);
    void'(model.pop_front());
    chk("R6 full pop+push status", rdData, exp);
    chk("R6 full pop+push dropped", 32'(fillLevel), DEPTH - 1);
    chk("R7 not full", 32'(respFull), 0);
    while (model.size() > 0) begin
      peekCheck("R6 drained bytes");
      popCheck("R6 drained status");
    end
    chk("R6 ovf sticky", 32'(overflowFlag), 1);
    chk("R7 empty at end", 32'(respEmpty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_empty();
    t_pair();
    t_full();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule